// File: doc/BRIEF.md
# Asynchronous Strobed Bus Master

This block connects a processor core to a 16-bit external bus on which each transfer ends only when the addressed device acknowledges it. The core hands over one request at a time. A request holds a 24-bit byte address, a write flag, a size flag (byte or word), write data and a 3-bit function code. The master places the upper 23 address bits on the bus. It keeps bit 0 internal and uses it to choose which of two active-low byte strobes to assert. It lowers the address strobe and then waits for as many clocks as the device needs. When the device acknowledges, the master returns read data or an error flag to the core.

The controller is a six-state machine:
- `ST_IDLE` accepts a request, or enters `ST_HALT` when a halt is requested.
- `ST_ADDR` drives the address, the strobes and the direction for one clock.
- `ST_WAIT` also drives write data and waits for the acknowledge input, the bus-error input or the optional timeout.
- `ST_DONE` releases all strobes and presents the response to the core for one clock.
- `ST_RECOVER` waits until the acknowledge and bus-error inputs have both returned high. It then goes to `ST_IDLE`, or to `ST_HALT` if a halt is pending.
- `ST_HALT` stays there until the halt request drops, then returns to `ST_IDLE`.

Top module: `async_bus_master`

## Requirements
- R1: `bus_addr` equals bits 23..1 of the accepted request address. It stays stable while `bus_as_n` is low.
- R2: Strobe encoding (active low), for reads and writes alike:
  - A word transfer drives `bus_uds_n`=0 and `bus_lds_n`=0.
  - A byte transfer with address bit 0 = 0 drives `bus_uds_n`=0 and `bus_lds_n`=1.
  - A byte transfer with address bit 0 = 1 drives `bus_uds_n`=1 and `bus_lds_n`=0.
  - Outside a cycle both strobes are 1.
- R3: `bus_as_n` goes low in the clock after a request is accepted.
  - `bus_rw` is 1 for a read and 0 for a write during the cycle, and 1 outside a cycle.
  - `bus_doe` is 1 only for writes, starting one clock after `bus_as_n` falls.
- R4: A cycle stays open for any number of clocks until `bus_dtack_n` is sampled low.
  - On the next clock `rsp_valid` is 1 for one clock, with all strobes released.
  - For a read, `rsp_rdata` holds the data present on `bus_din` when the acknowledge was sampled.
- R5: `bus_fc` takes the request's function code when the address strobe falls. It keeps that value until the next request is accepted.
- R6: If `bus_berr_n` is sampled low during a cycle, the cycle ends with `rsp_err`=1. This also holds when `bus_dtack_n` is low in the same clock.
- R7: A halt request raised during a cycle lets that cycle finish and respond. After that, `halted` is 1, `req_ready` is 0 and no new cycle starts until the halt request drops.
- R8: After a cycle ends, no new cycle starts and `req_ready` stays 0 until `bus_dtack_n` and `bus_berr_n` are both high.
- R9: Byte lanes:
  - A byte write drives write-data bits 7..0 onto both halves of `bus_dout`.
  - A byte read returns the selected lane in `rsp_rdata[7:0]`, with `rsp_rdata[15:8]`=0. The upper lane, `bus_din[15:8]`, belongs to address bit 0 = 0.
- R10: When the timeout is enabled and the cycle has spent `TIMEOUT_CYC` clocks (default 64) in the wait state without acknowledge or bus error, it ends with `rsp_err`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core presents a request |
| req_ready | output | 1 | Master can accept a request this clock |
| req_addr | input | 24 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_wdata | input | 16 | Write data (byte in bits 7..0) |
| req_fc | input | 3 | Function code for the cycle |
| rsp_valid | output | 1 | One-clock response pulse |
| rsp_err | output | 1 | Cycle ended by bus error or timeout |
| rsp_rdata | output | 16 | Read data, byte right-aligned |
| halt_req | input | 1 | Stop after the current cycle |
| halted | output | 1 | Master is halted |
| bus_addr | output | 23 | Word address, bits 23..1 |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_uds_n | output | 1 | Upper byte strobe, active low |
| bus_lds_n | output | 1 | Lower byte strobe, active low |
| bus_fc | output | 3 | Function code |
| bus_dout | output | 16 | Write data onto the bus |
| bus_doe | output | 1 | Write data drive enable |
| bus_din | input | 16 | Read data from the bus |
| bus_dtack_n | input | 1 | Transfer acknowledge, active low |
| bus_berr_n | input | 1 | Bus error, active low |

## Verification
The bench goes after the following corner cases:
- Odd and even byte addresses. A design that swapped lanes would strobe and return the wrong byte.
- Byte writes. A design that failed to replicate would leave one half of `bus_dout` undriven by the byte.
- Bus error arriving together with acknowledge. A design with the wrong priority would report success.
- An acknowledge held low after the response. A design that skipped recovery would start a second cycle that the slow device misreads as already acknowledged.
- A wait of exactly the timeout length, to catch an off-by-one in the counter.
- A halt raised mid-cycle. A design that stopped at once would lose that cycle's response.

// File: rtl/asb_pkg.sv
package asb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ADDR    = 3'd1,
        ST_WAIT    = 3'd2,
        ST_DONE    = 3'd3,
        ST_RECOVER = 3'd4,
        ST_HALT    = 3'd5
    } bus_state_e;

endpackage

// File: rtl/asb_lane_steer.sv
module asb_lane_steer #(
    parameter int DATA_W = 16
) (
    input  logic              word,
    input  logic              a0,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] din,
    output logic              upper_sel,
    output logic              lower_sel,
    output logic [DATA_W-1:0] dout,
    output logic [DATA_W-1:0] rdata
);
    localparam int LANE_W = DATA_W / 2;

    // Even byte address maps to the upper lane.
    assign upper_sel = word | ~a0;
    assign lower_sel = word | a0;

    always_comb begin
        if (word) begin
            dout  = wdata;
            rdata = din;
        end else begin
            dout  = {wdata[LANE_W-1:0], wdata[LANE_W-1:0]};
            rdata = a0 ? {{LANE_W{1'b0}}, din[LANE_W-1:0]}
                       : {{LANE_W{1'b0}}, din[DATA_W-1:LANE_W]};
        end
    end

    // R2: a byte transfer selects exactly one lane
    always_comb begin
        if (!word) begin
            a_r2_single_lane: assert ($onehot({upper_sel, lower_sel}));
        end
    end

endmodule

// File: rtl/asb_wait_timer.sv
module asb_wait_timer #(
    parameter bit ENABLE = 1'b1,
    parameter int LIMIT  = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

    generate
        if (ENABLE) begin : g_count
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     cnt_q <= '0;
                else if (clear) cnt_q <= '0;
                else if (run)   cnt_q <= cnt_q + 1'b1;
            end

            assign expired = run && (cnt_q == CW'(LIMIT - 1));

            // R10: the wait count never passes the limit
            a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
                run |-> (cnt_q < CW'(LIMIT)));
        end else begin : g_none
            logic unused_timer_inputs;
            assign unused_timer_inputs = ^{clk, rst_n, clear, run};
            assign expired = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/async_bus_master.sv
module async_bus_master
    import asb_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int DATA_W      = 16,
    parameter int FC_W        = 3,
    parameter bit TIMEOUT_EN  = 1'b1,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [FC_W-1:0]   req_fc,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              halt_req,
    output logic              halted,
    output logic [ADDR_W-2:0] bus_addr,
    output logic              bus_as_n,
    output logic              bus_rw,
    output logic              bus_uds_n,
    output logic              bus_lds_n,
    output logic [FC_W-1:0]   bus_fc,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    input  logic [DATA_W-1:0] bus_din,
    input  logic              bus_dtack_n,
    input  logic              bus_berr_n
);
    bus_state_e state_q, state_d;

    logic              wr_q, word_q, err_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic [FC_W-1:0]   fc_q;

    logic accept, ack_seen, berr_seen, timed_out, finish, in_cycle;
    logic upper_sel, lower_sel;
    logic [DATA_W-1:0] dout_lanes, rdata_lanes;

    assign accept    = (state_q == ST_IDLE) && !halt_req && req_valid;
    assign ack_seen  = !bus_dtack_n;
    assign berr_seen = !bus_berr_n;
    assign finish    = (state_q == ST_WAIT) && (ack_seen || berr_seen || timed_out);

    asb_lane_steer #(.DATA_W(DATA_W)) u_lanes (
        .word      (word_q),
        .a0        (addr_q[0]),
        .wdata     (wdata_q),
        .din       (bus_din),
        .upper_sel (upper_sel),
        .lower_sel (lower_sel),
        .dout      (dout_lanes),
        .rdata     (rdata_lanes)
    );

    asb_wait_timer #(.ENABLE(TIMEOUT_EN), .LIMIT(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state_q == ST_ADDR),
        .run     (state_q == ST_WAIT),
        .expired (timed_out)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (halt_req)       state_d = ST_HALT;
                else if (req_valid) state_d = ST_ADDR;
            end
            ST_ADDR:    state_d = ST_WAIT;
            ST_WAIT:    if (finish) state_d = ST_DONE;
            ST_DONE:    state_d = ST_RECOVER;
            ST_RECOVER: begin
                if (bus_dtack_n && bus_berr_n)
                    state_d = halt_req ? ST_HALT : ST_IDLE;
            end
            ST_HALT:    if (!halt_req) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            word_q  <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            fc_q    <= '0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                wr_q    <= req_write;
                word_q  <= req_word;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                fc_q    <= req_fc;
            end
            if (finish) begin
                err_q   <= berr_seen || !ack_seen;
                rdata_q <= rdata_lanes;
            end
        end
    end

    always_comb begin
        in_cycle  = (state_q == ST_ADDR) || (state_q == ST_WAIT);
        bus_addr  = addr_q[ADDR_W-1:1];
        bus_fc    = fc_q;
        bus_as_n  = !in_cycle;
        bus_uds_n = !(in_cycle && upper_sel);
        bus_lds_n = !(in_cycle && lower_sel);
        bus_rw    = !(in_cycle && wr_q);
        bus_doe   = (state_q == ST_WAIT) && wr_q;
        bus_dout  = dout_lanes;
        req_ready = (state_q == ST_IDLE) && !halt_req;
        rsp_valid = (state_q == ST_DONE);
        rsp_err   = err_q;
        rsp_rdata = rdata_q;
        halted    = (state_q == ST_HALT);
    end

    // R2: a data strobe is only active under the address strobe
    a_r2_strobe_under_as: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_uds_n || !bus_lds_n) |-> !bus_as_n);

    // R1: word address stays put while the strobe is low
    a_r1_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_as_n && !$past(bus_as_n)) |-> $stable(bus_addr));

    // R5: function code stays put through the cycle
    a_r5_fc_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_as_n && !$past(bus_as_n)) |-> $stable(bus_fc));

    // R3: data drive only for a write, after the strobe has already been low
    a_r3_doe_late: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_doe) |-> (!bus_rw && !bus_as_n && !$past(bus_as_n)));

    // R4: the response comes with all strobes released
    a_r4_rsp_released: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (bus_as_n && bus_uds_n && bus_lds_n));

    // R8: a new strobe never starts while the previous responses are held
    a_r8_clean_start: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_as_n) |-> ($past(bus_dtack_n) && $past(bus_berr_n)));

    // R7: halted master stays off the bus
    a_r7_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (bus_as_n && !req_ready));

endmodule

// File: tb/async_bus_master_test.sv
module async_bus_master_test;
    localparam int CLK_PERIOD  = 10;
    localparam int TIMEOUT_CYC = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_word = 1'b0;
    logic [15:0] req_wdata = '0;
    logic [2:0]  req_fc = '0;
    logic        rsp_valid, rsp_err;
    logic [15:0] rsp_rdata;
    logic        halt_req = 1'b0;
    logic        halted;
    logic [22:0] bus_addr;
    logic        bus_as_n, bus_rw, bus_uds_n, bus_lds_n, bus_doe;
    logic [2:0]  bus_fc;
    logic [15:0] bus_dout;
    logic [15:0] bus_din = '0;
    logic        bus_dtack_n = 1'b1;
    logic        bus_berr_n = 1'b1;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    async_bus_master #(.TIMEOUT_CYC(TIMEOUT_CYC)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_word(req_word), .req_wdata(req_wdata),
        .req_fc(req_fc), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .halt_req(halt_req), .halted(halted),
        .bus_addr(bus_addr), .bus_as_n(bus_as_n), .bus_rw(bus_rw),
        .bus_uds_n(bus_uds_n), .bus_lds_n(bus_lds_n), .bus_fc(bus_fc),
        .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
        .bus_dtack_n(bus_dtack_n), .bus_berr_n(bus_berr_n)
    );

    // term: 0 acknowledge, 1 bus error, 2 both together
    typedef struct packed {
        logic        wr;
        logic        word;
        logic [23:0] addr;
        logic [15:0] wdata;
        logic [2:0]  fc;
        logic [3:0]  delay;
        logic [1:0]  term;
        logic [15:0] din;
        logic        exp_uds_n;
        logic        exp_lds_n;
        logic [15:0] exp_dout;
        logic [15:0] exp_rdata;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 24'h000100, 16'h0000, 3'd5, 4'd0,  2'd0, 16'hA55A, 1'b0, 1'b0, 16'h0000, 16'hA55A},
        '{1'b0, 1'b0, 24'h012346, 16'h0000, 3'd1, 4'd1,  2'd0, 16'hBEEF, 1'b0, 1'b1, 16'h0000, 16'h00BE},
        '{1'b0, 1'b0, 24'h012347, 16'h0000, 3'd2, 4'd2,  2'd0, 16'hBEEF, 1'b1, 1'b0, 16'h0000, 16'h00EF},
        '{1'b1, 1'b1, 24'hFFFFFE, 16'h1234, 3'd6, 4'd3,  2'd0, 16'h0000, 1'b0, 1'b0, 16'h1234, 16'h0000},
        '{1'b1, 1'b0, 24'h000010, 16'hA75C, 3'd1, 4'd0,  2'd0, 16'h0000, 1'b0, 1'b1, 16'h5C5C, 16'h0000},
        '{1'b1, 1'b0, 24'h000011, 16'h00C3, 3'd2, 4'd2,  2'd0, 16'h0000, 1'b1, 1'b0, 16'hC3C3, 16'h0000},
        '{1'b0, 1'b1, 24'h7FFF02, 16'h0000, 3'd5, 4'd1,  2'd1, 16'h1111, 1'b0, 1'b0, 16'h0000, 16'h0000},
        '{1'b1, 1'b1, 24'h000200, 16'hFACE, 3'd6, 4'd0,  2'd2, 16'h0000, 1'b0, 1'b0, 16'hFACE, 16'h0000},
        '{1'b0, 1'b1, 24'h000400, 16'h0000, 3'd1, 4'd12, 2'd0, 16'h8001, 1'b0, 1'b0, 16'h0000, 16'h8001}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Present a request at a falling edge; returns in the address phase.
    task automatic issue(input logic wr, input logic word, input logic [23:0] addr,
                         input logic [15:0] wdata, input logic [2:0] fc);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_word  = word;
        req_addr  = addr;
        req_wdata = wdata;
        req_fc    = fc;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic run_vec(input vec_t v);
        bus_din = v.din;
        issue(v.wr, v.word, v.addr, v.wdata, v.fc);
        check("R3 as low in address phase", 32'(bus_as_n), 32'd0);
        check("R1 word address", 32'(bus_addr), 32'(v.addr[23:1]));
        check("R2 upper strobe", 32'(bus_uds_n), 32'(v.exp_uds_n));
        check("R2 lower strobe", 32'(bus_lds_n), 32'(v.exp_lds_n));
        check("R3 direction", 32'(bus_rw), 32'(!v.wr));
        check("R5 function code", 32'(bus_fc), 32'(v.fc));
        check("R3 no data drive with strobe", 32'(bus_doe), 32'd0);
        for (int i = 0; i <= int'(v.delay); i++) begin
            @(negedge clk);
            check("R4 cycle still open", 32'({bus_as_n, rsp_valid}), 32'd0);
            check("R3 data drive in wait", 32'(bus_doe), 32'(v.wr));
            if (v.wr) check("R9 write lanes", 32'(bus_dout), 32'(v.exp_dout));
        end
        bus_dtack_n = (v.term == 2'd1);
        bus_berr_n  = (v.term == 2'd0);
        @(negedge clk);
        check("R4 response pulse", 32'(rsp_valid), 32'd1);
        check("R4 strobes released", 32'({bus_as_n, bus_uds_n, bus_lds_n}), 32'h7);
        check("R6 error flag", 32'(rsp_err), 32'(v.term != 2'd0));
        if (!v.wr && v.term == 2'd0) check("R9 read data", 32'(rsp_rdata), 32'(v.exp_rdata));
        bus_dtack_n = 1'b1;
        bus_berr_n  = 1'b1;
        @(negedge clk);
        check("R4 single response", 32'(rsp_valid), 32'd0);
        @(negedge clk);
        check("R8 ready after release", 32'(req_ready), 32'd1);
        check("R5 code held after cycle", 32'(bus_fc), 32'(v.fc));
        check("R2 idle strobes", 32'({bus_uds_n, bus_lds_n, bus_rw}), 32'h7);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int waits;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 reset strobes", 32'({bus_as_n, bus_uds_n, bus_lds_n}), 32'h7);
        check("R3 reset direction", 32'({bus_rw, bus_doe}), 32'h2);
        check("R4 reset response", 32'({req_ready, rsp_valid, halted}), 32'h4);

        for (int k = 0; k < NV; k++) run_vec(VECS[k]);

        // R8: acknowledge held low after the response blocks a new cycle
        issue(1'b0, 1'b1, 24'h000800, 16'h0, 3'd2);
        @(negedge clk);
        bus_dtack_n = 1'b0;
        @(negedge clk);
        check("R8 response with ack held", 32'(rsp_valid), 32'd1);
        req_valid = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R8 no restart while ack low", 32'({req_ready, bus_as_n}), 32'h1);
        end
        req_valid = 1'b0;
        bus_dtack_n = 1'b1;
        @(negedge clk);
        check("R8 ready after ack high", 32'(req_ready), 32'd1);

        // R10: timeout after exactly TIMEOUT_CYC wait clocks
        issue(1'b0, 1'b1, 24'h001000, 16'h0, 3'd5);
        waits = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (rsp_valid) break;
            waits++;
        end
        check("R10 wait length", 32'(waits), 32'(TIMEOUT_CYC));
        check("R10 timeout error", 32'({rsp_valid, rsp_err}), 32'h3);
        repeat (2) @(negedge clk);

        // R7: halt raised mid-cycle
        issue(1'b1, 1'b0, 24'h002001, 16'h0077, 3'd6);
        @(negedge clk);
        halt_req = 1'b1;
        bus_dtack_n = 1'b0;
        @(negedge clk);
        check("R7 cycle completes under halt", 32'({rsp_valid, rsp_err}), 32'h2);
        bus_dtack_n = 1'b1;
        req_valid = 1'b1;
        repeat (2) @(negedge clk);
        check("R7 halted", 32'({halted, req_ready}), 32'h2);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R7 no cycle while halted", 32'(bus_as_n), 32'd1);
        end
        req_valid = 1'b0;
        halt_req = 1'b0;
        @(negedge clk);
        check("R7 resumes", 32'({halted, req_ready}), 32'h1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule